// File: doc/BRIEF.md
# Precision-time exchange calculator (slave side)

This block sits in the slave node of a network that synchronises time by exchanging packets. For each exchange it collects four 64-bit nanosecond timestamps. T2 is the local arrival time of a sync message. T1 is the master's send time for that sync, which arrives later in a follow-up message. T3 is the local send time of a delay request. T4 is the master's arrival time for that request, which comes back in a delay response. From these four values it computes the mean path delay and the offset from the master, which is what a servo needs to correct local time.

Follow-up and delay-response messages are paired with their local captures by sequence identifier. A message that does not pair is dropped, and the exchange restarts. Each accepted follow-up is compared with the one before it, and the block derives the ratio of local to master elapsed time over that span. The ratio comes from a bit-serial divider in unsigned Q2.30 format, with a busy/done handshake.

Top module: `ptp_exchange_calc`

## Requirements
- R1: A synchronous active-high reset clears all stored timestamps, the stored previous sync pair, the outputs, the divider, and the ratio (to 0). It returns the exchange to waiting for a sync.
- R2: A sync strobe is taken in any state, and it takes priority over other strobes in the same cycle. It stores T2 and its sequence identifier, then moves to waiting for the follow-up. An exchange that is under way is abandoned.
- R3: When the block is waiting for a follow-up, a follow-up whose sequence identifier equals the stored sync identifier stores T1 and moves to waiting for a delay request. One with any other identifier is discarded, and the block returns to waiting for a sync.
- R4: A delay request is recorded as T3, with its identifier, only while the block waits for one. Follow-up, delay-request and delay-response strobes that arrive in any other state have no effect.
- R5: A delay response whose identifier matches the stored request identifier causes res_valid in the next cycle. At the same time res_delay = ((T2−T1)+(T4−T3)) >>> 1 and res_offset = (T2−T1) − res_delay. All arithmetic is signed two's complement modulo 2^64, and the shift rounds toward minus infinity. A response with any other identifier raises no result. In both cases the block returns to waiting for a sync.
- R6: res_valid is high for exactly one cycle per completed exchange. res_offset and res_delay hold their values between results.
- R7: An accepted follow-up starts the divider when three conditions hold: a previous accepted pair (T1p, T2p) exists, DM = T1−T1p is non-zero, and the divider is idle. The quotient is floor((T2−T2p)·2^30 / DM), with both differences taken as unsigned. ratio_busy is high for the 32 cycles that follow the start edge. ratio_done pulses for one cycle as busy drops, and ratio updates at the same moment.
- R8: If (T2−T2p) ≥ 4·DM, no iterations run and busy stays low. In the next cycle ratio_done pulses and ratio becomes 32'hFFFF_FFFF.
- R9: If DM is zero or the divider is busy, no division starts and ratio keeps its value. The accepted pair still becomes the previous pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_stb | input | 1 | Sync arrival strobe |
| sync_ts | input | 64 | Local arrival time T2 |
| sync_seq | input | 16 | Sync sequence identifier |
| fup_stb | input | 1 | Follow-up strobe |
| fup_ts | input | 64 | Master send time T1 |
| fup_seq | input | 16 | Follow-up sequence identifier |
| dreq_stb | input | 1 | Delay request sent strobe |
| dreq_ts | input | 64 | Local send time T3 |
| dreq_seq | input | 16 | Delay request sequence identifier |
| dresp_stb | input | 1 | Delay response strobe |
| dresp_ts | input | 64 | Master arrival time T4 |
| dresp_seq | input | 16 | Delay response sequence identifier |
| res_valid | output | 1 | One-cycle result strobe |
| res_offset | output | 64 | Signed offset from master |
| res_delay | output | 64 | Signed mean path delay |
| ratio_busy | output | 1 | Divider running |
| ratio_done | output | 1 | One-cycle ratio update strobe |
| ratio | output | 32 | Rate ratio, unsigned Q2.30 |

## Verification
The hardest cases to reach are a follow-up that arrives while the divider is still working through an earlier interval, and the saturation path. The stimulus reaches the first by sending two complete exchanges far fewer than 32 cycles apart. It reaches the second by choosing a master interval much shorter than the local one. Both runs also cover a repeated T1, which gives a zero interval. Mismatched identifiers, out-of-order strobes and a sync that cuts into an exchange are sent between valid exchanges. Each of these has to leave the following result correct.

// File: rtl/ptp_exchange_calc.sv
module ptp_exchange_calc #(
  parameter int TS_W  = 64,
  parameter int SEQ_W = 16,
  parameter int Q_W   = 32,
  parameter int FRAC  = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_stb,
  input  logic [TS_W-1:0]    sync_ts,
  input  logic [SEQ_W-1:0]   sync_seq,
  input  logic               fup_stb,
  input  logic [TS_W-1:0]    fup_ts,
  input  logic [SEQ_W-1:0]   fup_seq,
  input  logic               dreq_stb,
  input  logic [TS_W-1:0]    dreq_ts,
  input  logic [SEQ_W-1:0]   dreq_seq,
  input  logic               dresp_stb,
  input  logic [TS_W-1:0]    dresp_ts,
  input  logic [SEQ_W-1:0]   dresp_seq,
  output logic               res_valid,
  output logic [TS_W-1:0]    res_offset,
  output logic [TS_W-1:0]    res_delay,
  output logic               ratio_busy,
  output logic               ratio_done,
  output logic [Q_W-1:0]     ratio
);
  localparam int CNT_W = $clog2(Q_W + 1);
  localparam int INT_B = Q_W - FRAC;

  typedef enum logic [1:0] {W_SYNC, W_FUP, W_DREQ, W_DRESP} st_t;
  st_t st;

  logic [TS_W-1:0]  t1, t2, t3, t1p, t2p;
  logic [SEQ_W-1:0] seq2, seq3;
  logic             pok;

  logic [TS_W-1:0]  rem, dvs;
  logic [Q_W-1:0]   feed, quo;
  logic [CNT_W-1:0] cnt;

  logic                   fup_ok, resp_ok, start, sat, ge;
  logic [TS_W-1:0]        dm, ds, ms, sm;
  logic signed [TS_W-1:0] sum_s, dly_s;
  logic [TS_W:0]          trial, diff;

  assign fup_ok  = !sync_stb && st == W_FUP && fup_stb && fup_seq == seq2;
  assign resp_ok = !sync_stb && st == W_DRESP && dresp_stb && dresp_seq == seq3;
  assign dm      = fup_ts - t1p;
  assign ds      = t2 - t2p;
  assign start   = fup_ok && pok && dm != '0 && !ratio_busy;
  assign sat     = (ds >> INT_B) >= dm;

  assign ms    = t2 - t1;
  assign sm    = dresp_ts - t3;
  assign sum_s = $signed(ms + sm);
  assign dly_s = sum_s >>> 1;

  assign trial = {rem, feed[Q_W-1]};
  assign diff  = trial - {1'b0, dvs};
  assign ge    = trial >= {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= W_SYNC;
      t1 <= '0; t2 <= '0; t3 <= '0; t1p <= '0; t2p <= '0;
      seq2 <= '0; seq3 <= '0; pok <= 1'b0;
      res_valid <= 1'b0; res_offset <= '0; res_delay <= '0;
    end else begin
      res_valid <= 1'b0;
      if (sync_stb) begin
        t2 <= sync_ts; seq2 <= sync_seq; st <= W_FUP;
      end else begin
        case (st)
          W_FUP: if (fup_stb) begin
            if (fup_ok) begin
              t1 <= fup_ts; t1p <= fup_ts; t2p <= t2; pok <= 1'b1; st <= W_DREQ;
            end else st <= W_SYNC;
          end
          W_DREQ: if (dreq_stb) begin
            t3 <= dreq_ts; seq3 <= dreq_seq; st <= W_DRESP;
          end
          W_DRESP: if (dresp_stb) begin
            if (resp_ok) begin
              res_valid  <= 1'b1;
              res_delay  <= dly_s;
              res_offset <= ms - dly_s;
            end
            st <= W_SYNC;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0; dvs <= '0; feed <= '0; quo <= '0; cnt <= '0;
      ratio_busy <= 1'b0; ratio_done <= 1'b0; ratio <= '0;
    end else begin
      ratio_done <= 1'b0;
      if (ratio_busy) begin
        rem  <= ge ? diff[TS_W-1:0] : trial[TS_W-1:0];
        quo  <= {quo[Q_W-2:0], ge};
        feed <= feed << 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          ratio_busy <= 1'b0;
          ratio_done <= 1'b1;
          ratio      <= {quo[Q_W-2:0], ge};
        end
      end else if (start) begin
        if (sat) begin
          ratio_done <= 1'b1;
          ratio      <= '1;
        end else begin
          rem  <= ds >> INT_B;
          dvs  <= dm;
          feed <= {ds[INT_B-1:0], {FRAC{1'b0}}};
          quo  <= '0;
          cnt  <= CNT_W'(Q_W);
          ratio_busy <= 1'b1;
        end
      end
    end
  end

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  a_r5_valid_from_resp: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(dresp_stb));
  a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(ratio_busy) |-> ratio_done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    ratio_done |-> !ratio_busy);
  a_r8_sat_value: assert property (@(posedge clk) disable iff (rst)
    (ratio_done && !$past(ratio_busy)) |-> ratio == '1);
  a_r9_ratio_held: assert property (@(posedge clk) disable iff (rst)
    !ratio_done |-> $stable(ratio));
endmodule

// File: tb/ptp_exchange_calc_test.sv
module ptp_exchange_calc_test;
  logic clk = 1'b0, rst = 1'b1;
  logic sync_stb = 0, fup_stb = 0, dreq_stb = 0, dresp_stb = 0;
  logic [63:0] sync_ts = 0, fup_ts = 0, dreq_ts = 0, dresp_ts = 0;
  logic [15:0] sync_seq = 0, fup_seq = 0, dreq_seq = 0, dresp_seq = 0;
  logic res_valid, ratio_busy, ratio_done;
  logic [63:0] res_offset, res_delay;
  logic [31:0] ratio;

  always #4 clk = ~clk;

  ptp_exchange_calc uut (
    .clk(clk), .rst(rst),
    .sync_stb(sync_stb), .sync_ts(sync_ts), .sync_seq(sync_seq),
    .fup_stb(fup_stb), .fup_ts(fup_ts), .fup_seq(fup_seq),
    .dreq_stb(dreq_stb), .dreq_ts(dreq_ts), .dreq_seq(dreq_seq),
    .dresp_stb(dresp_stb), .dresp_ts(dresp_ts), .dresp_seq(dresp_seq),
    .res_valid(res_valid), .res_offset(res_offset), .res_delay(res_delay),
    .ratio_busy(ratio_busy), .ratio_done(ratio_done), .ratio(ratio));

  int errors = 0, checks = 0;
  string phase = "R1 reset";

  // behavioural reference model
  int st = 0, cnt = 0;
  logic [63:0] m1, m2, m3, p1, p2;
  logic [15:0] q2, q3;
  bit pok = 0;
  bit e_valid = 0, e_busy = 0, e_done = 0;
  logic [63:0] e_off = 0, e_dly = 0;
  logic [31:0] e_ratio = 0, pend = 0;

  always @(posedge clk) begin
    bit was_busy;
    logic [63:0] dm, ds, a, b, s;
    logic [95:0] num;
    e_valid = 0; e_done = 0;
    if (rst) begin
      st = 0; m1 = 0; m2 = 0; m3 = 0; p1 = 0; p2 = 0; q2 = 0; q3 = 0; pok = 0;
      e_off = 0; e_dly = 0; e_busy = 0; e_ratio = 0; cnt = 0;
    end else begin
      was_busy = e_busy;
      if (e_busy) begin
        cnt--;
        if (cnt == 0) begin e_busy = 0; e_done = 1; e_ratio = pend; end
      end
      if (sync_stb) begin m2 = sync_ts; q2 = sync_seq; st = 1; end
      else if (st == 1 && fup_stb) begin
        if (fup_seq == q2) begin
          dm = fup_ts - p1; ds = m2 - p2;
          if (pok && dm != 0 && !was_busy) begin
            if ((ds >> 2) >= dm) begin e_done = 1; e_ratio = 32'hFFFF_FFFF; end
            else begin
              num = {ds, 30'b0};
              pend = 32'(num / {32'b0, dm});
              e_busy = 1; cnt = 32;
            end
          end
          m1 = fup_ts; p1 = fup_ts; p2 = m2; pok = 1; st = 2;
        end else st = 0;
      end else if (st == 2 && dreq_stb) begin m3 = dreq_ts; q3 = dreq_seq; st = 3; end
      else if (st == 3 && dresp_stb) begin
        if (dresp_seq == q3) begin
          a = m2 - m1; b = dresp_ts - m3; s = a + b;
          e_dly = 64'($signed(s) >>> 1);
          e_off = a - e_dly;
          e_valid = 1;
        end
        st = 0;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk("R6 res_valid", 64'(res_valid), 64'(e_valid));
    chk("R5 res_offset", res_offset, e_off);
    chk("R5 res_delay", res_delay, e_dly);
    chk("R7 ratio_busy", 64'(ratio_busy), 64'(e_busy));
    chk("R7 ratio_done", 64'(ratio_done), 64'(e_done));
    chk("R8 ratio", 64'(ratio), 64'(e_ratio));
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic ev(int k, logic [63:0] ts, logic [15:0] sq);
    case (k)
      0: begin sync_stb = 1; sync_ts = ts; sync_seq = sq; end
      1: begin fup_stb = 1; fup_ts = ts; fup_seq = sq; end
      2: begin dreq_stb = 1; dreq_ts = ts; dreq_seq = sq; end
      default: begin dresp_stb = 1; dresp_ts = ts; dresp_seq = sq; end
    endcase
    tick(1);
    sync_stb = 0; fup_stb = 0; dreq_stb = 0; dresp_stb = 0;
    tick(1);
  endtask

  task automatic xchg(logic [63:0] t1, t2, t3, t4, logic [15:0] sq);
    ev(0, t2, sq); ev(1, t1, sq); ev(2, t3, sq); ev(3, t4, sq);
  endtask

  bit dog = 0;
  initial begin
    #(8 * 150000);
    dog = 1; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    @(negedge clk);
    chk("R1 reset valid", 64'(res_valid), 0);
    chk("R1 reset busy", 64'(ratio_busy), 0);
    chk("R1 reset ratio", 64'(ratio), 0);
    #2 rst = 0; tick(2);

    phase = "R5 positive offset";
    xchg(64'd1_000_000, 64'd1_000_500, 64'd1_002_000, 64'd1_002_300, 16'd1);
    tick(2);
    phase = "R7 ratio near one";
    xchg(64'd1_000_000_900, 64'd1_000_001_500, 64'd1_000_003_000, 64'd1_000_003_600, 16'd2);
    tick(40);
    phase = "R5 negative offset";
    xchg(64'd2_000_000_000, 64'd2_000_000_100, 64'd2_000_001_000, 64'd2_000_001_700, 16'd3);
    tick(40);
    phase = "R5 odd negative sum";
    xchg(64'd3_000_000_010, 64'd3_000_000_005, 64'd3_000_000_100, 64'd3_000_000_100, 16'd4);
    tick(40);

    phase = "R3 mismatched follow-up";
    ev(0, 64'd4_000_000_000, 16'd5); ev(1, 64'd3_999_999_000, 16'd9);
    ev(2, 64'd4_000_000_500, 16'd5); ev(3, 64'd4_000_000_900, 16'd5);
    tick(40);
    phase = "R5 mismatched response";
    ev(0, 64'd5_000_000_000, 16'd6); ev(1, 64'd4_999_999_000, 16'd6);
    ev(2, 64'd5_000_000_500, 16'd6); ev(3, 64'd5_000_000_900, 16'd7);
    tick(40);
    phase = "R4 out-of-order strobes";
    ev(2, 64'd77, 16'd8); ev(3, 64'd99, 16'd8); ev(1, 64'd55, 16'd8);
    ev(0, 64'd6_000_000_300, 16'd8); ev(3, 64'd11, 16'd8);
    ev(1, 64'd6_000_000_000, 16'd8); ev(1, 64'd1, 16'd8);
    ev(2, 64'd6_000_001_000, 16'd8); ev(2, 64'd5, 16'd8);
    ev(3, 64'd6_000_001_200, 16'd8);
    tick(40);
    phase = "R2 sync restarts exchange";
    ev(0, 64'd7_000_000_000, 16'd10); ev(1, 64'd6_999_999_000, 16'd10);
    ev(0, 64'd7_000_000_400, 16'd11); ev(1, 64'd6_999_999_900, 16'd10);
    ev(1, 64'd7_000_000_000, 16'd11);
    ev(2, 64'd7_000_000_800, 16'd11); ev(3, 64'd7_000_001_100, 16'd11);
    tick(40);
    phase = "R9 zero master interval";
    xchg(64'd7_000_000_000, 64'd7_000_002_000, 64'd7_000_003_000, 64'd7_000_003_100, 16'd12);
    tick(40);
    phase = "R8 saturation";
    xchg(64'd7_000_000_100, 64'd8_000_000_000, 64'd8_000_000_500, 64'd7_000_000_700, 16'd13);
    tick(40);
    phase = "R9 follow-up while busy";
    xchg(64'd9_000_000_000, 64'd9_000_000_050, 64'd9_000_000_300, 64'd9_000_000_330, 16'd14);
    xchg(64'd9_000_010_000, 64'd9_000_010_080, 64'd9_000_010_400, 64'd9_000_010_420, 16'd15);
    tick(40);
    xchg(64'd9_003_010_000, 64'd9_003_011_000, 64'd9_003_012_000, 64'd9_003_012_300, 16'd16);
    tick(40);

    phase = "R7 swept exchanges";
    for (int i = 0; i < 12; i++) begin
      logic [63:0] b1;
      b1 = 64'd10_000_000_000 + 64'(i) * 64'd125_000_017;
      xchg(b1, b1 + 64'(i * 37) - 64'd200, b1 + 64'd5000, b1 + 64'd5000 + 64'(i * 11),
           16'(100 + i));
      tick(36);
    end

    phase = "R1 reset mid-run";
    ev(0, 64'd1, 16'd1);
    #0 rst = 1; tick(2); rst = 0; tick(1);
    xchg(64'd20_000, 64'd20_400, 64'd21_000, 64'd21_200, 16'd1);
    xchg(64'd40_000, 64'd40_500, 64'd41_000, 64'd41_300, 16'd2);
    tick(40);

    if (!dog) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule